// File: doc/BRIEF.md
# Three-Input Bitwise Truth-Table Unit

This unit evaluates an arbitrary three-input Boolean function across three wide operand vectors, one bit position at a time. An 8-bit function code acts as a truth table. At every bit position, the bits taken from operands A, B and C form a 3-bit index, and the code bit at that index becomes the result bit. With this one code the unit can produce any of the 256 possible three-input functions, such as majority, parity, select or plain AND/OR, without a separate opcode for each.

The operands are split into elements of 32 or 64 bits. An optional per-element write mask chooses, for each element, whether the function result is written. An element that is not written either keeps its operand A value (merge) or becomes zero (zero fill). Operand A stands for the old destination contents. The result goes into a register on a valid input and appears one cycle later together with a valid output.

Top module: `tri_truth_unit`

## Requirements
- R1: For every bit position i, result[i] equals funcCode[{srcA[i], srcB[i], srcC[i]}]. The A bit is the most significant index bit and the C bit is the least significant.
- R2: With masking disabled, funcCode 8'h00 yields an all-zero result and funcCode 8'hFF yields an all-ones result, whatever the operands are.
- R3: The following codes give these functions: 8'hE8 majority (1 when at least two inputs are 1), 8'h17 minority (its inverse), 8'h96 three-input XOR, 8'h80 three-input AND, 8'hFE three-input OR.
- R4: The codes 8'hF0, 8'hCC and 8'hAA return operand A, operand B and operand C unchanged.
- R5: When maskEn is 0, every element receives the function result and maskBits has no effect.
- R6: With wideElem = 0 (32-bit elements) and maskEn = 1, maskBits[j] decides whether result bits [32j+31:32j] receive the function result.
- R7: With wideElem = 1 (64-bit elements) and maskEn = 1, maskBits[j] for j = 0..7 decides for bits [64j+63:64j], and maskBits[15:8] have no effect.
- R8: An element whose mask bit is 0 takes the matching bits of srcA when zeroMode = 0, and all zeros when zeroMode = 1.
- R9: outValid is high in exactly the cycle after a cycle with inValid high. In that same cycle, result holds the value computed from the inputs presented with inValid.
- R10: While inValid is low, result keeps its last value, even if the other inputs change.
- R11: A synchronous reset clears outValid and result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Inputs are valid and must be captured this cycle |
| srcA | input | 512 | First operand; also stands for the old destination |
| srcB | input | 512 | Second operand |
| srcC | input | 512 | Third operand |
| funcCode | input | 8 | Truth table of the three-input function |
| wideElem | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| maskEn | input | 1 | Apply the per-element write mask |
| maskBits | input | 16 | Per-element mask, bit j governs element j |
| zeroMode | input | 1 | 0: unmasked-off elements keep srcA, 1: they are zeroed |
| outValid | output | 1 | Result register was loaded in the previous cycle |
| result | output | 512 | Registered function result |

## Verification
The unit has a single register stage. A wrong lane-keep decision or a wrong index order therefore shows up at result in the very cycle that outValid rises, and a bad capture strobe shows up as a value that changes while inValid is low. The truth-table index is checked against a bit-by-bit reference for all 256 codes on random operands. The mask paths are driven with patterns that tell a 32-bit mapping from a 64-bit one and that tell merge from zero fill. The stimulus in each case is chosen so that a swapped operand, a dropped lane or an ignored upper mask half changes at least one compared bit.

// File: rtl/tri_truth_pkg.sv
package tri_truth_pkg;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic capture;     // load the result register this cycle
    logic wideLanes;   // lanes pair up into 64-bit elements
    logic maskActive;  // per-element mask applies
    logic zeroFill;    // masked-off lanes clear instead of merging
  } ttStrobe_t;

endpackage

// File: rtl/tri_truth_ctrl.sv
module tri_truth_ctrl
  import tri_truth_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      wideElem,
  input  logic      maskEn,
  input  logic      zeroMode,
  output ttStrobe_t strobe,
  output logic      outValid
);

  always_comb begin
    strobe.capture    = inValid;
    strobe.wideLanes  = wideElem;
    strobe.maskActive = maskEn;
    strobe.zeroFill   = zeroMode;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R9: valid output follows valid input by exactly one cycle
  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/tri_truth_datapath.sv
module tri_truth_datapath
  import tri_truth_pkg::*;
#(
  parameter int DATA_W   = 512,
  parameter int LANE_W   = 32,
  parameter int PAIR_CNT = 2,
  localparam int LANES   = DATA_W / LANE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  ttStrobe_t         strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcC,
  input  logic [7:0]        funcCode,
  input  logic [LANES-1:0]  maskBits,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] rawBits;
  logic [DATA_W-1:0] nextRes;
  logic [LANES-1:0]  laneKeep;

  // Per-bit truth-table lookup: index is {A,B,C}, A most significant
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      rawBits[i] = funcCode[{srcA[i], srcB[i], srcC[i]}];
    end
  end

  // Lane-granular write mask; wide elements share one mask bit per pair
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int WIDE_IDX = l / PAIR_CNT;
    assign laneKeep[l] = !strobe.maskActive |
                         (strobe.wideLanes ? maskBits[WIDE_IDX] : maskBits[l]);
    assign nextRes[l*LANE_W +: LANE_W] =
        laneKeep[l] ? rawBits[l*LANE_W +: LANE_W]
                    : (strobe.zeroFill ? {LANE_W{1'b0}} : srcA[l*LANE_W +: LANE_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)                 result <= '0;
    else if (strobe.capture) result <= nextRes;
  end

  // R10: result holds without a capture
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(result));
  // R8: zero fill with every mask bit clear empties the result
  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && strobe.maskActive && strobe.zeroFill && maskBits == '0)
      |=> (result == '0));
  // R2: all-ones code without masking fills every bit
  assert_all_ones_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !strobe.maskActive && funcCode == 8'hFF) |=> (&result));
  // R2: all-zeros code without masking clears every bit
  assert_all_zeros_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !strobe.maskActive && funcCode == 8'h00) |=> (result == '0));

endmodule

// File: rtl/tri_truth_unit.sv
module tri_truth_unit
  import tri_truth_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int LANE_W = 32,
  localparam int LANES = DATA_W / LANE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcC,
  input  logic [7:0]        funcCode,
  input  logic              wideElem,
  input  logic              maskEn,
  input  logic [LANES-1:0]  maskBits,
  input  logic              zeroMode,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  ttStrobe_t strobe;

  tri_truth_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .wideElem(wideElem),
    .maskEn(maskEn), .zeroMode(zeroMode), .strobe(strobe), .outValid(outValid)
  );

  tri_truth_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W), .PAIR_CNT(2)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .srcA(srcA), .srcB(srcB),
    .srcC(srcC), .funcCode(funcCode), .maskBits(maskBits), .result(result)
  );

endmodule

// File: tb/tri_truth_unit_tb.sv
`timescale 1ns/1ps
module tri_truth_unit_tb;

  localparam int W = 512;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [W-1:0] srcA, srcB, srcC;
  logic [7:0]   funcCode;
  logic         wideElem, maskEn, zeroMode;
  logic [15:0]  maskBits;
  logic         outValid;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tri_truth_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .srcC(srcC), .funcCode(funcCode), .wideElem(wideElem), .maskEn(maskEn),
    .maskBits(maskBits), .zeroMode(zeroMode), .outValid(outValid), .result(result)
  );

  function automatic logic [W-1:0] rnd512();
    logic [W-1:0] v;
    for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Independent reference built from the requirement text
  function automatic logic [W-1:0] refModel(
      logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, logic [7:0] code,
      logic wide, logic men, logic [15:0] mb, logic zf);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int idx;
      int elem;
      logic keep;
      idx  = (a[i] ? 4 : 0) + (b[i] ? 2 : 0) + (c[i] ? 1 : 0);
      elem = wide ? i / 64 : i / 32;
      keep = !men || mb[elem];
      r[i] = keep ? code[idx] : (zf ? 1'b0 : a[i]);
    end
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Present one operation at a negedge, check at the following negedge
  task automatic runOp(string req, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                       logic [7:0] code, logic wide, logic men, logic [15:0] mb,
                       logic zf, logic [W-1:0] exp);
    srcA = a; srcB = b; srcC = c; funcCode = code;
    wideElem = wide; maskEn = men; maskBits = mb; zeroMode = zf;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit({req, " outValid"}, outValid, 1'b1);
    check(req, result, exp);
  endtask

  task automatic testReset();
    rst = 1'b1; inValid = 1'b0;
    srcA = '0; srcB = '0; srcC = '0; funcCode = 8'hFF;
    wideElem = 0; maskEn = 0; maskBits = '0; zeroMode = 0;
    repeat (3) @(negedge clk);
    checkBit("R11 outValid", outValid, 1'b0);
    check("R11 result", result, '0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic testIndexSweep();
    for (int code = 0; code < 256; code++) begin
      logic [W-1:0] a, b, c;
      a = rnd512(); b = rnd512(); c = rnd512();
      runOp("R1 index sweep", a, b, c, code[7:0], 0, 0, '0, 0,
            refModel(a, b, c, code[7:0], 0, 0, '0, 0));
    end
  endtask

  task automatic testConstants();
    logic [W-1:0] a, b, c;
    a = rnd512(); b = rnd512(); c = rnd512();
    runOp("R2 zeros", a, b, c, 8'h00, 0, 0, 16'hFFFF, 0, '0);
    runOp("R2 ones", a, b, c, 8'hFF, 1, 0, 16'h0000, 1, '1);
  endtask

  task automatic testNamed();
    logic [W-1:0] a, b, c;
    a = rnd512(); b = rnd512(); c = rnd512();
    runOp("R3 majority", a, b, c, 8'hE8, 0, 0, '0, 0, (a & b) | (a & c) | (b & c));
    runOp("R3 minority", a, b, c, 8'h17, 0, 0, '0, 0, ~((a & b) | (a & c) | (b & c)));
    runOp("R3 xor", a, b, c, 8'h96, 0, 0, '0, 0, a ^ b ^ c);
    runOp("R3 and", a, b, c, 8'h80, 0, 0, '0, 0, a & b & c);
    runOp("R3 or", a, b, c, 8'hFE, 0, 0, '0, 0, a | b | c);
  endtask

  task automatic testPassThrough();
    logic [W-1:0] a, b, c;
    a = rnd512(); b = rnd512(); c = rnd512();
    runOp("R4 pass A", a, b, c, 8'hF0, 0, 0, '0, 0, a);
    runOp("R4 pass B", a, b, c, 8'hCC, 0, 0, '0, 0, b);
    runOp("R4 pass C", a, b, c, 8'hAA, 0, 0, '0, 0, c);
  endtask

  task automatic testNoMask();
    logic [W-1:0] a, b, c;
    a = rnd512(); b = rnd512(); c = rnd512();
    runOp("R5 mask ignored", a, b, c, 8'h96, 0, 0, 16'h0000, 1, a ^ b ^ c);
  endtask

  task automatic testNarrowMask();
    logic [W-1:0] a, b, c, exp;
    a = rnd512(); b = rnd512(); c = rnd512();
    for (int j = 0; j < 16; j++)
      exp[j*32 +: 32] = (16'hA5C3 >> j) & 1 ? (b[j*32 +: 32] & c[j*32 +: 32]) : a[j*32 +: 32];
    runOp("R6 narrow merge", a, b, c, 8'h88, 0, 1, 16'hA5C3, 0, exp);
    runOp("R6 narrow zero", a, b, c, 8'h88, 0, 1, 16'h3C5A, 1,
          refModel(a, b, c, 8'h88, 0, 1, 16'h3C5A, 1));
  endtask

  task automatic testWideMask();
    logic [W-1:0] a, b, c, exp;
    a = rnd512(); b = rnd512(); c = rnd512();
    for (int j = 0; j < 8; j++)
      exp[j*64 +: 64] = (8'h59 >> j) & 1 ? ~c[j*64 +: 64] : '0;
    runOp("R7 wide zero", a, b, c, 8'h55, 1, 1, 16'h0059, 1, exp);
    runOp("R7 upper bits ignored", a, b, c, 8'h55, 1, 1, 16'hFF59, 1, exp);
    runOp("R7 wide merge", a, b, c, 8'h55, 1, 1, 16'h00A6, 0,
          refModel(a, b, c, 8'h55, 1, 1, 16'h00A6, 0));
  endtask

  task automatic testMergeZero();
    logic [W-1:0] a, b, c;
    a = rnd512(); b = rnd512(); c = rnd512();
    runOp("R8 merge keeps A", a, b, c, 8'hFF, 0, 1, 16'h0000, 0, a);
    runOp("R8 zero clears", a, b, c, 8'hFF, 0, 1, 16'h0000, 1, '0);
  endtask

  task automatic testTiming();
    logic [W-1:0] a, b, c, held;
    a = rnd512(); b = rnd512(); c = rnd512();
    held = a | b | c;
    runOp("R9 one-cycle latency", a, b, c, 8'hFE, 0, 0, '0, 0, held);
    srcA = rnd512(); funcCode = 8'h00;
    @(negedge clk);
    checkBit("R9 outValid drops", outValid, 1'b0);
    check("R10 hold while idle", result, held);
    srcB = rnd512(); funcCode = 8'hFF;
    @(negedge clk);
    check("R10 hold second cycle", result, held);
  endtask

  initial begin
    testReset();
    testIndexSweep();
    testConstants();
    testNamed();
    testPassThrough();
    testNoMask();
    testNarrowMask();
    testWideMask();
    testMergeZero();
    testTiming();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkBit("R11 reset mid-run outValid", outValid, 1'b0);
    check("R11 reset mid-run result", result, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule